// File: doc/BRIEF.md
# Load/Store Address Sequencer

This block carries out the data-memory side of the load and store instructions of a 16-bit processor. When `start` is raised with a memory instruction, it captures the instruction, the address of the next instruction, a base register value and the value to be stored. It then works out the effective address for one of four addressing modes and runs the one or two accesses that mode needs on a single synchronous memory port.

Loads end with a write-back request that carries the result, the destination register index and a condition-code triple. Stores end with the word already written to memory. A one-cycle `done` pulse marks the end of every operation, and `busy` is high from acceptance until that pulse. Fetch, the decoding of other opcodes and the register file belong to the surrounding core.

Top module: `mem_access_seq`

## Requirements
- R1: Only seven opcodes in `instr[15:12]` are accepted: load-direct 0010, load-indirect 1010, load-base 0110, load-address 1110, store-direct 0011, store-indirect 1011 and store-base 0111. A `start` with any other opcode is ignored: `busy` and `done` stay low and there is no memory access.
- R2: Load-address (1110) returns `pc + sext(instr[8:0])` on `dst_val` and makes no memory access at all.
- R3: Direct modes (0010, 0011) read or write the word at `pc + sext(instr[8:0])`.
- R4: Indirect modes (1010, 1011) first read a pointer at `pc + sext(instr[8:0])`. They then read or write the word at the address held in that pointer.
- R5: Base modes (0110, 0111) access `base_val + sext(instr[5:0])`. `base_val` holds the register named in `instr[8:6]`.
- R6: A store writes `store_val` as sampled in the `start` cycle, and it never raises `dst_we` or `flag_we`.
- R7: `done` is a single-cycle pulse. Counting the `start` cycle as cycle 0, it arrives in cycle 1 for load-address, cycle 2 for the direct and base modes, and cycle 3 for the indirect modes.
- R8: In the `done` cycle, a load raises `dst_we` and `flag_we`, sets `dst_idx = instr[11:9]`, and sets `nzp` to 100 if the value has bit 15 set, 010 if it is zero, and 001 otherwise.
- R9: A `start` that arrives while `busy` is high is ignored and does not alter the operation in progress.
- R10: After reset the block is idle: `busy`, `done`, `mem_re` and `mem_we` are all low.
- R11: Memory reads have one cycle of latency. `mem_re` is high in the cycle the address is presented, and `mem_rdata` is used in the following cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Request to begin an operation |
| instr | input | 16 | Instruction word |
| pc | input | 16 | Address of the next instruction (already incremented) |
| base_val | input | 16 | Value of the base register for base modes |
| store_val | input | 16 | Value of the source register for stores |
| busy | output | 1 | Operation in progress |
| done | output | 1 | Completion pulse |
| mem_addr | output | 16 | Memory address |
| mem_re | output | 1 | Memory read enable |
| mem_we | output | 1 | Memory write enable |
| mem_wdata | output | 16 | Memory write data |
| mem_rdata | input | 16 | Memory read data, valid one cycle after `mem_re` |
| dst_we | output | 1 | Destination register write request |
| dst_idx | output | 3 | Destination register index |
| dst_val | output | 16 | Value to write back |
| flag_we | output | 1 | Condition-code update request |
| nzp | output | 3 | Condition code of `dst_val` (negative, zero, positive) |

## Verification
Random instructions drawn from all seven opcodes run with random offsets, PCs, base values and memory contents, so any mix-up between a PC-relative and a base-relative sum, or between a 9-bit and a 6-bit sign extension, shows up as a wrong address.

Directed cases cover:
- the extreme offsets of both fields, to separate sign extension from zero extension;
- loads of zero, negative and positive words, to separate the three condition codes;
- indirect chains, to separate the pointer word from the data word.

Between each start and its completion, the bench also scrambles every operand input, and it retries `start` during a busy operation and with unknown opcodes. This tells correct capture-at-start apart from logic that reads its inputs live.

// File: rtl/mas_pkg.sv
package mas_pkg;
  localparam int unsigned ISA_W      = 16;
  localparam int unsigned OPC_W      = 4;
  localparam int unsigned REG_IDX_W  = 3;
  localparam int unsigned OFF_PC_W   = 9;
  localparam int unsigned OFF_BASE_W = 6;
  localparam int unsigned CYC_W      = 2;
  localparam int unsigned NZP_W      = 3;

  typedef enum logic [1:0] {AM_IMM, AM_DIR, AM_IND, AM_BASE} amode_e;
  typedef enum logic [1:0] {SQ_IDLE, SQ_FIRST, SQ_SECOND, SQ_DONE} seq_state_e;

  typedef struct packed {
    logic   valid;
    logic   is_store;
    amode_e mode;
  } mem_op_t;

  function automatic logic [ISA_W-1:0] sext_pc_off(input logic [ISA_W-1:0] ins);
    return {{(ISA_W-OFF_PC_W){ins[OFF_PC_W-1]}}, ins[OFF_PC_W-1:0]};
  endfunction

  function automatic logic [ISA_W-1:0] sext_base_off(input logic [ISA_W-1:0] ins);
    return {{(ISA_W-OFF_BASE_W){ins[OFF_BASE_W-1]}}, ins[OFF_BASE_W-1:0]};
  endfunction

  function automatic logic [NZP_W-1:0] nzp_of(input logic [ISA_W-1:0] v);
    if (v[ISA_W-1])  return 3'b100;
    else if (v == '0) return 3'b010;
    else              return 3'b001;
  endfunction

  function automatic logic [CYC_W-1:0] latency_of(input amode_e m);
    case (m)
      AM_IMM:  return 2'd1;
      AM_IND:  return 2'd3;
      default: return 2'd2;
    endcase
  endfunction
endpackage

// File: rtl/mas_decode.sv
module mas_decode
  import mas_pkg::*;
(
  input  logic [ISA_W-1:0] instr,
  output mem_op_t          op
);
  logic [OPC_W-1:0] opc;
  assign opc = instr[ISA_W-1 -: OPC_W];

  always_comb begin
    op.valid    = 1'b1;
    op.is_store = 1'b0;
    op.mode     = AM_DIR;
    case (opc)
      4'b0010: op.mode = AM_DIR;
      4'b1010: op.mode = AM_IND;
      4'b0110: op.mode = AM_BASE;
      4'b1110: op.mode = AM_IMM;
      4'b0011: begin op.is_store = 1'b1; op.mode = AM_DIR;  end
      4'b1011: begin op.is_store = 1'b1; op.mode = AM_IND;  end
      4'b0111: begin op.is_store = 1'b1; op.mode = AM_BASE; end
      default: op.valid = 1'b0;
    endcase
  end
endmodule

// File: rtl/mas_addr_gen.sv
module mas_addr_gen
  import mas_pkg::*;
(
  input  logic [ISA_W-1:0] instr,
  input  logic [ISA_W-1:0] pc,
  input  logic [ISA_W-1:0] base_val,
  input  amode_e           mode,
  output logic [ISA_W-1:0] ea
);
  logic [ISA_W-1:0] pc_rel;
  logic [ISA_W-1:0] base_rel;

  assign pc_rel   = pc + sext_pc_off(instr);
  assign base_rel = base_val + sext_base_off(instr);
  assign ea       = (mode == AM_BASE) ? base_rel : pc_rel;
endmodule

// File: rtl/mas_ctrl.sv
module mas_ctrl
  import mas_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start,
  input  mem_op_t              op,
  input  logic [ISA_W-1:0]     ea,
  input  logic [ISA_W-1:0]     store_val,
  input  logic [REG_IDX_W-1:0] idx_in,
  input  logic [ISA_W-1:0]     mem_rdata,
  output logic [ISA_W-1:0]     mem_addr,
  output logic                 mem_re,
  output logic                 mem_we,
  output logic [ISA_W-1:0]     mem_wdata,
  output logic                 busy,
  output logic                 done,
  output logic                 dst_we,
  output logic [REG_IDX_W-1:0] dst_idx,
  output logic [ISA_W-1:0]     dst_val,
  output logic                 flag_we,
  output logic [NZP_W-1:0]     nzp
);
  seq_state_e           state_q;
  amode_e               mode_q;
  logic                 store_q;
  logic [ISA_W-1:0]     ea_q;
  logic [ISA_W-1:0]     wdata_q;
  logic [REG_IDX_W-1:0] idx_q;
  logic [CYC_W-1:0]     cyc_q;

  // Named internal events
  logic accept;
  logic first_step;
  logic ind_step;

  assign accept     = (state_q == SQ_IDLE) && start && op.valid;
  assign first_step = (state_q == SQ_FIRST);
  assign ind_step   = (state_q == SQ_SECOND);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= SQ_IDLE;
      mode_q  <= AM_DIR;
      store_q <= 1'b0;
      ea_q    <= '0;
      wdata_q <= '0;
      idx_q   <= '0;
      cyc_q   <= '0;
    end else begin
      case (state_q)
        SQ_IDLE: if (accept) begin
          mode_q  <= op.mode;
          store_q <= op.is_store;
          ea_q    <= ea;
          wdata_q <= store_val;
          idx_q   <= idx_in;
          cyc_q   <= 2'd1;
          state_q <= (op.mode == AM_IMM) ? SQ_DONE : SQ_FIRST;
        end
        SQ_FIRST: begin
          cyc_q   <= cyc_q + 2'd1;
          state_q <= (mode_q == AM_IND) ? SQ_SECOND : SQ_DONE;
        end
        SQ_SECOND: begin
          cyc_q   <= cyc_q + 2'd1;
          state_q <= SQ_DONE;
        end
        default: state_q <= SQ_IDLE;
      endcase
    end
  end

  always_comb begin
    mem_addr  = ind_step ? mem_rdata : ea_q;
    mem_wdata = wdata_q;
    mem_re    = (first_step && (!store_q || mode_q == AM_IND)) || (ind_step && !store_q);
    mem_we    = (first_step && store_q && mode_q != AM_IND) || (ind_step && store_q);
  end

  assign busy    = (state_q != SQ_IDLE);
  assign done    = (state_q == SQ_DONE);
  assign dst_we  = done && !store_q;
  assign flag_we = dst_we;
  assign dst_idx = idx_q;
  assign dst_val = !dst_we ? '0 : ((mode_q == AM_IMM) ? ea_q : mem_rdata);
  assign nzp     = dst_we ? nzp_of(dst_val) : '0;

  // Assertions
  a_r7_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  a_r7_latency: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (cyc_q == latency_of(mode_q)));
  a_r2_lea_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && mode_q == AM_IMM) |-> (!mem_re && !mem_we));
  a_r4_pointer_first: assert property (@(posedge clk) disable iff (!rst_n)
    ind_step |-> $past(mem_re));
  a_r6_store_no_writeback: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |=> !dst_we);
  a_r8_nzp_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    flag_we |-> $onehot(nzp));
  a_r9_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !done) |=> busy);
  a_r10_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!mem_re && !mem_we && !done));
endmodule

// File: rtl/mem_access_seq.sv
module mem_access_seq
  import mas_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic [15:0] instr,
  input  logic [15:0] pc,
  input  logic [15:0] base_val,
  input  logic [15:0] store_val,
  output logic        busy,
  output logic        done,
  output logic [15:0] mem_addr,
  output logic        mem_re,
  output logic        mem_we,
  output logic [15:0] mem_wdata,
  input  logic [15:0] mem_rdata,
  output logic        dst_we,
  output logic [2:0]  dst_idx,
  output logic [15:0] dst_val,
  output logic        flag_we,
  output logic [2:0]  nzp
);
  mem_op_t          op;
  logic [ISA_W-1:0] ea;

  mas_decode u_decode (
    .instr (instr),
    .op    (op)
  );

  mas_addr_gen u_addr (
    .instr    (instr),
    .pc       (pc),
    .base_val (base_val),
    .mode     (op.mode),
    .ea       (ea)
  );

  mas_ctrl u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .op        (op),
    .ea        (ea),
    .store_val (store_val),
    .idx_in    (instr[11:9]),
    .mem_rdata (mem_rdata),
    .mem_addr  (mem_addr),
    .mem_re    (mem_re),
    .mem_we    (mem_we),
    .mem_wdata (mem_wdata),
    .busy      (busy),
    .done      (done),
    .dst_we    (dst_we),
    .dst_idx   (dst_idx),
    .dst_val   (dst_val),
    .flag_we   (flag_we),
    .nzp       (nzp)
  );

  // R1: an unknown opcode never starts an operation
  a_r1_unknown_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && start && !op.valid) |=> !busy);
endmodule

// File: tb/tb_mem_access_seq.sv
`timescale 1ns/1ps
module tb_mem_access_seq;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [15:0] instr = '0, pc_in = '0, base_in = '0, store_in = '0;
  logic        busy, done, mem_re, mem_we, dst_we, flag_we;
  logic [15:0] mem_addr, mem_wdata, dst_val;
  logic [15:0] mem_rdata = '0;
  logic [2:0]  dst_idx, nzp;

  int n_chk = 0;
  int n_fail = 0;
  logic [15:0] mem [0:255];

  always #2 clk = ~clk;

  mem_access_seq dut (
    .clk(clk), .rst_n(rst_n), .start(start), .instr(instr), .pc(pc_in),
    .base_val(base_in), .store_val(store_in), .busy(busy), .done(done),
    .mem_addr(mem_addr), .mem_re(mem_re), .mem_we(mem_we), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .dst_we(dst_we), .dst_idx(dst_idx), .dst_val(dst_val),
    .flag_we(flag_we), .nzp(nzp)
  );

  // Memory model: one cycle read latency, 256 words aliased on the low address byte
  always @(posedge clk) begin
    if (mem_we) mem[mem_addr[7:0]] <= mem_wdata;
    if (mem_re) mem_rdata <= mem[mem_addr[7:0]];
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic logic [15:0] sx9(input logic [15:0] ins);
    logic signed [15:0] t;
    t = $signed({ins[8:0], 7'b0}) >>> 7;
    return t;
  endfunction

  function automatic logic [15:0] sx6(input logic [15:0] ins);
    logic signed [15:0] t;
    t = $signed({ins[5:0], 10'b0}) >>> 10;
    return t;
  endfunction

  function automatic logic [2:0] exp_flags(input logic [15:0] v);
    if ($signed(v) < 0) return 3'b100;
    if (v == 16'd0)     return 3'b010;
    return 3'b001;
  endfunction

  function automatic int lat_of(input logic [3:0] opc);
    case (opc)
      4'b1110: return 1;
      4'b0010, 4'b0110, 4'b0011, 4'b0111: return 2;
      4'b1010, 4'b1011: return 3;
      default: return 0;
    endcase
  endfunction

  function automatic string tag_of(input logic [3:0] opc);
    case (opc)
      4'b1110: return "R2";
      4'b0010, 4'b0011: return "R3";
      4'b1010, 4'b1011: return "R4";
      default: return "R5";
    endcase
  endfunction

  task automatic run_op(input logic [15:0] ins, input logic [15:0] pcv,
                        input logic [15:0] bv, input logic [15:0] sv, input bit poke);
    logic [3:0]  opc;
    int          lat, got;
    bit          st, acc, is_base, is_ind;
    string       tg;
    logic [15:0] ea, tgt, expv;
    opc     = ins[15:12];
    lat     = lat_of(opc);
    tg      = tag_of(opc);
    st      = (opc == 4'b0011) || (opc == 4'b1011) || (opc == 4'b0111);
    is_base = (opc == 4'b0110) || (opc == 4'b0111);
    is_ind  = (opc == 4'b1010) || (opc == 4'b1011);
    ea      = is_base ? bv + sx6(ins) : pcv + sx9(ins);
    tgt     = is_ind ? mem[ea[7:0]] : ea;
    expv    = (opc == 4'b1110) ? ea : mem[tgt[7:0]];

    @(negedge clk);
    start = 1'b1; instr = ins; pc_in = pcv; base_in = bv; store_in = sv;
    @(negedge clk);
    start = 1'b0; instr = $urandom; pc_in = $urandom; base_in = $urandom; store_in = $urandom;
    got = 0; acc = 0;
    for (int n = 1; n <= 6; n++) begin
      if (done) begin got = n; break; end
      if (mem_re || mem_we) acc = 1;
      if (poke && n == 1) begin start = 1'b1; instr = 16'hE1FF; end
      if (poke && n == 2) start = 1'b0;
      @(negedge clk);
    end
    chk(got == lat, "R7", "done latency", 16'(got), 16'(lat));
    if (opc == 4'b1110) chk(!acc, "R2", "memory touched by load-address", 16'(acc), 16'd0);
    else                chk(acc, "R11", "no memory access", 16'(acc), 16'd1);
    if (got != 0) begin
      if (st) begin
        chk(!dst_we && !flag_we, "R6", "write-back on store", {14'b0, dst_we, flag_we}, 16'd0);
        chk(mem[tgt[7:0]] == sv, tg, "stored word", mem[tgt[7:0]], sv);
      end else begin
        chk(dst_we && flag_we, "R8", "write-back request", {14'b0, dst_we, flag_we}, 16'd3);
        chk(dst_val == expv, tg, "load value", dst_val, expv);
        chk(dst_idx == ins[11:9], "R8", "destination index", {13'b0, dst_idx}, {13'b0, ins[11:9]});
        chk(nzp == exp_flags(expv), "R8", "condition code", {13'b0, nzp}, {13'b0, exp_flags(expv)});
      end
    end
    @(negedge clk);
    chk(!done, "R7", "done longer than one cycle", {15'b0, done}, 16'd0);
    if (poke) begin
      for (int k = 0; k < 4; k++) begin
        chk(!busy && !done, "R9", "start during busy took effect", {14'b0, busy, done}, 16'd0);
        @(negedge clk);
      end
    end
  endtask

  task automatic try_unknown(input logic [15:0] ins);
    @(negedge clk);
    start = 1'b1; instr = ins;
    @(negedge clk);
    start = 1'b0;
    for (int k = 0; k < 4; k++) begin
      chk(!busy && !done && !mem_re && !mem_we, "R1", "unknown opcode acted",
          {12'b0, busy, done, mem_re, mem_we}, 16'd0);
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL R7 watchdog: actual run hung, expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [3:0] ops [0:6];
    void'($urandom(32'h5EED));
    for (int i = 0; i < 256; i++) mem[i] = 16'($urandom);
    ops[0] = 4'b0010; ops[1] = 4'b1010; ops[2] = 4'b0110; ops[3] = 4'b1110;
    ops[4] = 4'b0011; ops[5] = 4'b1011; ops[6] = 4'b0111;

    repeat (3) @(negedge clk);
    chk(!busy && !done && !mem_re && !mem_we, "R10", "reset state",
        {12'b0, busy, done, mem_re, mem_we}, 16'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy && !done, "R10", "idle after reset", {14'b0, busy, done}, 16'd0);

    // Directed: offset extremes
    run_op(16'hE100, 16'h3050, 16'h0, 16'h0, 1'b0);  // LEA offset -256
    run_op(16'hE0FF, 16'h3050, 16'h0, 16'h0, 1'b0);  // LEA offset +255
    run_op(16'h6460, 16'h0, 16'h0120, 16'h0, 1'b0);  // LDR offset -32
    run_op(16'h645F, 16'h0, 16'h0120, 16'h0, 1'b0);  // LDR offset +31
    // Directed: condition codes
    mem[8'h45] = 16'h0000; run_op(16'h2605, 16'h0040, 16'h0, 16'h0, 1'b0);
    mem[8'h46] = 16'h8001; run_op(16'h2606, 16'h0040, 16'h0, 16'h0, 1'b0);
    mem[8'h47] = 16'h0007; run_op(16'h2607, 16'h0040, 16'h0, 16'h0, 1'b0);
    // Directed: indirect chains
    mem[8'h10] = 16'h0033; mem[8'h33] = 16'hBEEF;
    run_op(16'hA210, 16'h0000, 16'h0, 16'h0, 1'b0);
    mem[8'h11] = 16'h0077;
    run_op(16'hB211, 16'h0000, 16'h0, 16'hCAFE, 1'b0);
    run_op(16'h3A02, 16'h0090, 16'h0, 16'h1234, 1'b0);
    run_op(16'h7A7F, 16'h0, 16'h0050, 16'h4321, 1'b0);
    // Directed: start while busy
    mem[8'h20] = 16'h0044;
    run_op(16'hA420, 16'h0000, 16'h0, 16'h0, 1'b1);
    // Directed: unknown opcodes
    try_unknown(16'h1000);
    try_unknown(16'h0000);
    try_unknown(16'hF025);
    try_unknown(16'hC1C0);

    // Constrained random
    for (int i = 0; i < 120; i++) begin
      logic [15:0] ins;
      ins = {ops[$urandom % 7], 12'($urandom)};
      run_op(ins, 16'($urandom), 16'($urandom), 16'($urandom), 1'b0);
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule